// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Demap

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a page-aligned virtual address, a 2-bit page-size code, a partition ID, a context ID, a real-mode flag, a lock flag, a physical page address, and valid and used bits. A lookup compares the request against every slot in the same cycle. On a hit, the block returns the physical address. That address takes its page bits from the slot and its offset bits from the request.

Commands arrive on a valid/ready interface, and the block accepts at most one per cycle. The commands are: insert, lookup, demap of one page, demap of a context, demap of all unlocked slots in a partition, invalidate all, and diagnostic reads of the tag word and the data word of a slot. Every accepted command produces a registered response one cycle later. Replacement follows a not-recently-used policy with one used bit per slot. Locked slots keep their used bit when the used bits are cleared.

Top module: `tlb_fa`

## Requirements
- R1: While reset is high, `cmd_ready` and `rsp_valid` are low. After reset, every slot is invalid, so a lookup misses.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high. Each accepted command makes `rsp_valid` high on the next cycle, with `rsp_op` equal to the accepted opcode. Without an accepted command, `rsp_valid` is low. Opcodes are 0 insert, 1 lookup, 2 demap page, 3 demap context, 4 demap partition, 5 invalidate all, 6 read tag, 7 read data.
- R3: A lookup hits a slot when all of these hold: the slot is valid, its partition, context and real flag equal the request's, and the request address with its offset bits cleared equals the slot address. The slot's size code gives the number of offset bits: 0 gives 13, 1 gives 16, 2 gives 22, 3 gives 28. On a hit, `rsp_hit`=1, `rsp_idx` is the slot, and `rsp_pa` = (slot PA AND NOT mask) OR (request VA AND mask).
- R4: A lookup miss returns `rsp_hit`=0 and `rsp_pa`=0.
- R5: An insert writes the lowest-index slot that is invalid or has its used bit clear. If no such slot exists, it writes the last slot. The written slot becomes valid and used, its address is stored with the offset bits cleared, and `rsp_idx` reports the slot.
- R6: An insert first invalidates any valid slot with the same page address, size code, partition, context and real flag.
- R7: An insert or a lookup can set a used bit. If that update leaves every used bit set, all unlocked slots lose their used bit, except the slot just marked.
- R8: A lookup hit sets the used bit of the slot it hits.
- R9: Demap page invalidates every slot that a lookup with the same fields would hit, including locked slots.
- R10: Demap context invalidates every slot whose context and partition both match the command, including locked slots.
- R11: Demap partition invalidates only the unlocked slots of the given partition. Locked slots and other partitions keep their translations.
- R12: Invalidate all clears every valid bit and every used bit, so the next insert uses slot 0.
- R13: Read tag returns the following word:
  - partition ID in bits 63:61
  - real flag in bit 60
  - inverted size code in bits 57:56
  - stored page address ORed with the context ID in the low bits

  Read data returns the following word:
  - valid bit in bit 63
  - size code in bits 62:61
  - physical address bits PA_W-1:13 in place
  - lock flag in bit 6
  - every other bit zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode |
| cmd_va | input | VA_W | Virtual address |
| cmd_size | input | 2 | Page size code for insert |
| cmd_part | input | PART_W | Partition ID |
| cmd_ctx | input | CTX_W | Context ID |
| cmd_real | input | 1 | Real-mode translation flag |
| cmd_lock | input | 1 | Lock flag for insert |
| cmd_pa | input | PA_W | Physical address for insert |
| cmd_idx | input | IDX_W | Slot for diagnostic reads |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 3 | Opcode of the answered command |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | IDX_W | Hit slot, written slot or read slot |
| rsp_pa | output | PA_W | Composed physical address |
| rsp_word | output | 64 | Tag or data readback word |

## Verification
The bench runs the block with eight slots and checks the replacement order slot by slot. One sequence makes the used-bit clear fire in the middle of the run. A design that clears too early, or that ignores the used bit set by a hit, would pick the wrong slot. With every slot locked, the last-slot fallback must be chosen twice in a row. A design that let locked slots lose their used bit would instead start filling slot 0. The three demap levels are each applied to a mix of locked and unlocked slots across two partitions. A wrong rule shows up as a hit that should miss, or as a miss that should hit. The PA composition is swept over all four page sizes with zero, all-ones and mixed offsets, so a swapped mask width corrupts the returned address.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

  typedef enum logic [2:0] {
    OP_INSERT     = 3'd0,
    OP_LOOKUP     = 3'd1,
    OP_DEMAP_PAGE = 3'd2,
    OP_DEMAP_CTX  = 3'd3,
    OP_DEMAP_PART = 3'd4,
    OP_INVAL_ALL  = 3'd5,
    OP_READ_TAG   = 3'd6,
    OP_READ_DATA  = 3'd7
  } tlb_op_e;

  // number of page-offset bits selected by a size code
  function automatic logic [4:0] page_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd13;
      2'd1:    return 5'd16;
      2'd2:    return 5'd22;
      default: return 5'd28;
    endcase
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_fa_pkg::*;
#(
  parameter int N      = 64,
  parameter int VA_W   = 48,
  parameter int CTX_W  = 13,
  parameter int PART_W = 3
) (
  input  logic [N-1:0]      e_valid,
  input  logic [N-1:0]      e_lock,
  input  logic [N-1:0]      e_real,
  input  logic [VA_W-1:0]   e_va   [N],
  input  logic [1:0]        e_size [N],
  input  logic [PART_W-1:0] e_part [N],
  input  logic [CTX_W-1:0]  e_ctx  [N],
  input  logic [VA_W-1:0]   q_va,
  input  logic [VA_W-1:0]   q_va_pg,
  input  logic [1:0]        q_size,
  input  logic [PART_W-1:0] q_part,
  input  logic [CTX_W-1:0]  q_ctx,
  input  logic              q_real,
  output logic [N-1:0]      m_xlate,
  output logic [N-1:0]      m_exact,
  output logic [N-1:0]      m_ctx,
  output logic [N-1:0]      m_part_unl
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [VA_W-1:0] msk;
    logic            part_eq;
    logic            id_eq;
    assign msk     = ~({VA_W{1'b1}} << page_shift(e_size[g]));
    assign part_eq = (e_part[g] == q_part);
    assign id_eq   = part_eq && (e_ctx[g] == q_ctx) && (e_real[g] == q_real);

    assign m_xlate[g]    = e_valid[g] && id_eq && ((q_va & ~msk) == e_va[g]);
    assign m_exact[g]    = e_valid[g] && id_eq && (e_size[g] == q_size) &&
                           (e_va[g] == q_va_pg);
    assign m_ctx[g]      = part_eq && (e_ctx[g] == q_ctx);
    assign m_part_unl[g] = part_eq && !e_lock[g];
  end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_nru.sv
module tlb_nru #(
  parameter int N = 64
) (
  input  logic [N-1:0] used_cur,
  input  logic [N-1:0] lock_nxt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] used_nxt
);

  always_comb begin
    used_nxt = (used_cur & ~clr) | set;
    if ((|set) && (&used_nxt)) used_nxt = (used_nxt & lock_nxt) | set;
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 13,
  parameter int PART_W  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [1:0]        cmd_size,
  input  logic [PART_W-1:0] cmd_part,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_real,
  input  logic              cmd_lock,
  input  logic [PA_W-1:0]   cmd_pa,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              rsp_valid,
  output logic [2:0]        rsp_op,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [63:0]       rsp_word
);

  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  // slot storage: fields without reset, written only on insert
  logic [VA_W-1:0]   va_q   [ENTRIES];
  logic [1:0]        size_q [ENTRIES];
  logic [PART_W-1:0] part_q [ENTRIES];
  logic [CTX_W-1:0]  ctx_q  [ENTRIES];
  logic [PA_W-1:0]   pa_q   [ENTRIES];
  logic [ENTRIES-1:0] real_q;
  // state bits with reset
  logic [ENTRIES-1:0] valid_q, used_q, lock_q;
  logic               ready_q;

  tlb_op_e op;
  logic    accept;
  assign op        = tlb_op_e'(cmd_op);
  assign accept    = cmd_valid && ready_q;
  assign cmd_ready = ready_q;

  logic [VA_W-1:0] ins_va;
  assign ins_va = cmd_va & ({VA_W{1'b1}} << page_shift(cmd_size));

  logic [ENTRIES-1:0] m_xlate, m_exact, m_ctx, m_part_unl;

  tlb_cam #(
    .N(ENTRIES), .VA_W(VA_W), .CTX_W(CTX_W), .PART_W(PART_W)
  ) u_cam (
    .e_valid   (valid_q),
    .e_lock    (lock_q),
    .e_real    (real_q),
    .e_va      (va_q),
    .e_size    (size_q),
    .e_part    (part_q),
    .e_ctx     (ctx_q),
    .q_va      (cmd_va),
    .q_va_pg   (ins_va),
    .q_size    (cmd_size),
    .q_part    (cmd_part),
    .q_ctx     (cmd_ctx),
    .q_real    (cmd_real),
    .m_xlate   (m_xlate),
    .m_exact   (m_exact),
    .m_ctx     (m_ctx),
    .m_part_unl(m_part_unl)
  );

  logic             free_found, hit_found;
  logic [IDX_W-1:0] free_idx, hit_idx, victim;

  tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
    .req  (~valid_q | ~used_q),
    .found(free_found),
    .idx  (free_idx)
  );

  tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit (
    .req  (m_xlate),
    .found(hit_found),
    .idx  (hit_idx)
  );

  assign victim = free_found ? free_idx : IDX_W'(ENTRIES - 1);

  // per-command update vectors
  logic [ENTRIES-1:0] clr_v, mark_v, fill_v, lock_nxt, used_nxt, valid_nxt;

  always_comb begin
    clr_v    = '0;
    mark_v   = '0;
    fill_v   = '0;
    lock_nxt = lock_q;
    if (accept) begin
      case (op)
        OP_INSERT: begin
          clr_v            = m_exact;
          fill_v           = ONE << victim;
          mark_v           = fill_v;
          lock_nxt[victim] = cmd_lock;
        end
        OP_LOOKUP:     if (hit_found) mark_v = (ONE << hit_idx) & ~used_q;
        OP_DEMAP_PAGE: clr_v = m_xlate;
        OP_DEMAP_CTX:  clr_v = m_ctx;
        OP_DEMAP_PART: clr_v = m_part_unl;
        OP_INVAL_ALL:  clr_v = '1;
        default: ;
      endcase
    end
  end

  assign valid_nxt = (valid_q & ~clr_v) | fill_v;

  tlb_nru #(.N(ENTRIES)) u_nru (
    .used_cur(used_q),
    .lock_nxt(lock_nxt),
    .clr     (clr_v),
    .set     (mark_v),
    .used_nxt(used_nxt)
  );

  // response datapath
  logic [PA_W-1:0] pa_msk, pa_out;
  logic [1:0]      inv_sz;
  logic [63:0]     tag_w, data_w, word_n;

  assign pa_msk = ~({PA_W{1'b1}} << page_shift(size_q[hit_idx]));
  assign pa_out = (pa_q[hit_idx] & ~pa_msk) | (PA_W'(cmd_va) & pa_msk);
  assign inv_sz = ~size_q[cmd_idx];

  always_comb begin
    tag_w = (64'(part_q[cmd_idx]) << 61) | (64'(real_q[cmd_idx]) << 60) |
            (64'(inv_sz) << 56) | 64'(va_q[cmd_idx]) | 64'(ctx_q[cmd_idx]);
    data_w              = '0;
    data_w[63]          = valid_q[cmd_idx];
    data_w[62:61]       = size_q[cmd_idx];
    data_w[PA_W-1:13]   = pa_q[cmd_idx][PA_W-1:13];
    data_w[6]           = lock_q[cmd_idx];
    case (op)
      OP_READ_TAG:  word_n = tag_w;
      OP_READ_DATA: word_n = data_w;
      default:      word_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      valid_q   <= '0;
      used_q    <= '0;
      lock_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_op    <= '0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_pa    <= '0;
      rsp_word  <= '0;
    end else begin
      ready_q   <= 1'b1;
      valid_q   <= valid_nxt;
      used_q    <= used_nxt;
      lock_q    <= lock_nxt;
      rsp_valid <= accept;
      if (accept) begin
        rsp_op   <= cmd_op;
        rsp_hit  <= (op == OP_LOOKUP) && hit_found;
        rsp_pa   <= ((op == OP_LOOKUP) && hit_found) ? pa_out : '0;
        rsp_word <= word_n;
        case (op)
          OP_INSERT: rsp_idx <= victim;
          OP_LOOKUP: rsp_idx <= hit_idx;
          default:   rsp_idx <= cmd_idx;
        endcase
      end
    end
  end

  // field storage, RAM style (no reset)
  always_ff @(posedge clk) begin
    if (accept && op == OP_INSERT) begin
      va_q[victim]   <= ins_va;
      size_q[victim] <= cmd_size;
      part_q[victim] <= cmd_part;
      ctx_q[victim]  <= cmd_ctx;
      pa_q[victim]   <= cmd_pa;
      real_q[victim] <= cmd_real;
    end
  end

  // ---------------- assertions ----------------
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (rsp_valid && rsp_op == $past(cmd_op)));

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);

  a_r4_miss_zero_pa: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));

  a_r5_insert_marks: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_INSERT) |=> (valid_q[rsp_idx] && used_q[rsp_idx]));

  a_r7_used_implies_valid: assert property (@(posedge clk) disable iff (rst)
    ((used_q & ~valid_q) == '0));

  a_r7_full_only_locked: assert property (@(posedge clk) disable iff (rst)
    (&used_q) |-> ($countones(~lock_q) <= 1));

  a_r11_locked_survive: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_DEMAP_PART) |=> (((valid_q ^ $past(valid_q)) & lock_q) == '0));

  a_r12_inval_clears: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_INVAL_ALL) |=> (valid_q == '0 && used_q == '0));

endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  import tlb_fa_pkg::*;

  localparam int N = 8, VA_W = 48, PA_W = 40, CTX_W = 13, PART_W = 3, IDX_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0, cmd_ready;
  logic [2:0]        cmd_op = '0;
  logic [VA_W-1:0]   cmd_va = '0;
  logic [1:0]        cmd_size = '0;
  logic [PART_W-1:0] cmd_part = '0;
  logic [CTX_W-1:0]  cmd_ctx = '0;
  logic              cmd_real = 1'b0, cmd_lock = 1'b0;
  logic [PA_W-1:0]   cmd_pa = '0;
  logic [IDX_W-1:0]  cmd_idx = '0;
  logic              rsp_valid, rsp_hit;
  logic [2:0]        rsp_op;
  logic [IDX_W-1:0]  rsp_idx;
  logic [PA_W-1:0]   rsp_pa;
  logic [63:0]       rsp_word;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  tlb_fa #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .PART_W(PART_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_size(cmd_size), .cmd_part(cmd_part),
    .cmd_ctx(cmd_ctx), .cmd_real(cmd_real), .cmd_lock(cmd_lock), .cmd_pa(cmd_pa),
    .cmd_idx(cmd_idx), .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_pa(rsp_pa), .rsp_word(rsp_word)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] offmask(input logic [1:0] s);
    int sh;
    sh = (s == 0) ? 13 : (s == 1) ? 16 : (s == 2) ? 22 : 28;
    return (64'd1 << sh) - 64'd1;
  endfunction

  function automatic logic [63:0] xpa(input logic [PA_W-1:0] pa, input logic [VA_W-1:0] va,
                                     input logic [1:0] s);
    logic [63:0] m;
    m = offmask(s);
    return (64'(pa) & ~m) | (64'(va) & m);
  endfunction

  task automatic issue(input tlb_op_e op, input logic [VA_W-1:0] va, input logic [1:0] sz,
                       input logic [PART_W-1:0] pt, input logic [CTX_W-1:0] cx,
                       input logic rl, input logic lk, input logic [PA_W-1:0] pa,
                       input logic [IDX_W-1:0] ix);
    @(negedge clk);
    cmd_op = op; cmd_va = va; cmd_size = sz; cmd_part = pt; cmd_ctx = cx;
    cmd_real = rl; cmd_lock = lk; cmd_pa = pa; cmd_idx = ix; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ins(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic [PART_W-1:0] pt,
                     input logic [CTX_W-1:0] cx, input logic rl, input logic lk,
                     input logic [PA_W-1:0] pa);
    issue(OP_INSERT, va, sz, pt, cx, rl, lk, pa, '0);
  endtask

  task automatic look(input logic [VA_W-1:0] va, input logic [PART_W-1:0] pt,
                      input logic [CTX_W-1:0] cx, input logic rl);
    issue(OP_LOOKUP, va, 2'd0, pt, cx, rl, 1'b0, '0, '0);
  endtask

  task automatic inval();
    issue(OP_INVAL_ALL, '0, 2'd0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [IDX_W-1:0] exp_seq [6];
    logic [VA_W-1:0]  va;
    logic [PA_W-1:0]  pa;
    logic [IDX_W-1:0] slot;

    // ---- reset (R1, R2)
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 64'(cmd_ready), 64'd0);
    chk("R1 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 ready after reset", 64'(cmd_ready), 64'd1);
    look(48'h0, 3'd0, 13'd0, 1'b0);
    chk("R2 rsp_valid after command", 64'(rsp_valid), 64'd1);
    chk("R2 rsp_op echoes lookup", 64'(rsp_op), 64'(OP_LOOKUP));
    chk("R1 empty lookup misses", 64'(rsp_hit), 64'd0);
    chk("R4 miss pa zero", 64'(rsp_pa), 64'd0);
    @(negedge clk);
    chk("R2 no response when idle", 64'(rsp_valid), 64'd0);

    // ---- fill sweep and PA check, 8 KB pages (R5, R3)
    for (int i = 0; i < N; i++) begin
      ins((48'(i) << 13) | 48'h55, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, (40'h100 + 40'(i)) << 13);
      chk("R5 fill order", 64'(rsp_idx), 64'(i));
    end
    for (int i = 0; i < N; i++) begin
      va = (48'(i) << 13) | 48'((i * 37 + 1) & 16'h1FFF);
      look(va, 3'd1, 13'd5, 1'b0);
      chk("R3 hit", 64'(rsp_hit), 64'd1);
      chk("R3 pa 8K", 64'(rsp_pa), xpa((40'h100 + 40'(i)) << 13, va, 2'd0));
    end

    // ---- size sweep (R3, R4)
    inval();
    for (int s = 0; s < 4; s++) begin
      pa = 40'hA5_5A5A_B6C8 ^ (40'(s) << 29);
      ins(48'(s + 1) << 32, 2'(s), 3'd2, 13'(s), 1'b0, 1'b0, pa);
    end
    for (int s = 0; s < 4; s++) begin
      pa = 40'hA5_5A5A_B6C8 ^ (40'(s) << 29);
      for (int k = 0; k < 3; k++) begin
        va = (48'(s + 1) << 32) |
             (48'((k == 0) ? 64'd0 : (k == 1) ? 64'hFFFF_FFFF : 64'h0123_4567) &
              48'(offmask(2'(s))));
        look(va, 3'd2, 13'(s), 1'b0);
        chk("R3 size hit", 64'(rsp_hit), 64'd1);
        chk("R3 size pa", 64'(rsp_pa), xpa(pa, va, 2'(s)));
      end
      look((48'(s + 1) << 32) + 48'(offmask(2'(s))) + 48'd1, 3'd2, 13'(s), 1'b0);
      chk("R4 next page misses", 64'(rsp_hit), 64'd0);
      look(48'(s + 1) << 32, 3'd2, 13'(s + 1), 1'b0);
      chk("R4 wrong context misses", 64'(rsp_hit), 64'd0);
      look(48'(s + 1) << 32, 3'd3, 13'(s), 1'b0);
      chk("R4 wrong partition misses", 64'(rsp_hit), 64'd0);
      look(48'(s + 1) << 32, 3'd2, 13'(s), 1'b1);
      chk("R4 wrong real flag misses", 64'(rsp_hit), 64'd0);
      chk("R4 miss pa zero", 64'(rsp_pa), 64'd0);
    end

    // ---- not-recently-used order (R7, R8)
    inval();
    for (int i = 0; i < N; i++) ins(48'(i) << 13, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 40'(i) << 13);
    ins(48'(16) << 13, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 40'h1000);
    chk("R7 victim after clear", 64'(rsp_idx), 64'd0);
    look(48'(3) << 13, 3'd1, 13'd5, 1'b0);
    chk("R8 hit before marking", 64'(rsp_hit), 64'd1);
    exp_seq = '{3'd1, 3'd2, 3'd4, 3'd5, 3'd6, 3'd0};
    for (int k = 0; k < 6; k++) begin
      ins(48'(17 + k) << 13, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 40'h2000);
      chk("R8 R7 victim sequence", 64'(rsp_idx), 64'(exp_seq[k]));
    end

    // ---- all locked: last-slot fallback (R5, R7)
    inval();
    for (int i = 0; i < N; i++) begin
      ins(48'(i) << 13, 2'd0, 3'd1, (i < 4) ? 13'd5 : 13'd6, 1'b0, 1'b1, 40'(i + 64) << 13);
      chk("R5 locked fill", 64'(rsp_idx), 64'(i));
    end
    ins(48'(20) << 13, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 40'h3000);
    chk("R5 fallback to last slot", 64'(rsp_idx), 64'(N - 1));
    look(48'(7) << 13, 3'd1, 13'd6, 1'b0);
    chk("R5 overwritten slot gone", 64'(rsp_hit), 64'd0);
    look(48'(20) << 13, 3'd1, 13'd5, 1'b0);
    chk("R5 new slot hits at last", 64'(rsp_idx), 64'(N - 1));
    ins(48'(21) << 13, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 40'h4000);
    chk("R7 locked keep used bits", 64'(rsp_idx), 64'(N - 1));

    // ---- demap levels (R11, R9, R10)
    issue(OP_DEMAP_PART, '0, 2'd0, 3'd2, '0, 1'b0, 1'b0, '0, '0);
    look(48'(21) << 13, 3'd1, 13'd5, 1'b0);
    chk("R11 other partition untouched", 64'(rsp_hit), 64'd1);
    issue(OP_DEMAP_PART, '0, 2'd0, 3'd1, '0, 1'b0, 1'b0, '0, '0);
    look(48'(21) << 13, 3'd1, 13'd5, 1'b0);
    chk("R11 unlocked removed", 64'(rsp_hit), 64'd0);
    look(48'(0), 3'd1, 13'd5, 1'b0);
    chk("R11 locked kept", 64'(rsp_hit), 64'd1);
    look(48'(5) << 13, 3'd1, 13'd6, 1'b0);
    chk("R11 locked kept ctx6", 64'(rsp_hit), 64'd1);
    issue(OP_DEMAP_PAGE, (48'(1) << 13) | 48'h7, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, '0, '0);
    look(48'(1) << 13, 3'd1, 13'd5, 1'b0);
    chk("R9 locked page removed", 64'(rsp_hit), 64'd0);
    look(48'(2) << 13, 3'd1, 13'd5, 1'b0);
    chk("R9 neighbour kept", 64'(rsp_hit), 64'd1);
    issue(OP_DEMAP_CTX, '0, 2'd0, 3'd2, 13'd6, 1'b0, 1'b0, '0, '0);
    look(48'(4) << 13, 3'd1, 13'd6, 1'b0);
    chk("R10 wrong partition kept", 64'(rsp_hit), 64'd1);
    issue(OP_DEMAP_CTX, '0, 2'd0, 3'd1, 13'd6, 1'b0, 1'b0, '0, '0);
    look(48'(4) << 13, 3'd1, 13'd6, 1'b0);
    chk("R10 locked ctx removed", 64'(rsp_hit), 64'd0);
    look(48'(6) << 13, 3'd1, 13'd6, 1'b0);
    chk("R10 locked ctx removed 2", 64'(rsp_hit), 64'd0);
    look(48'(3) << 13, 3'd1, 13'd5, 1'b0);
    chk("R10 other ctx kept", 64'(rsp_hit), 64'd1);

    // ---- duplicate insert (R6)
    inval();
    ins(48'h0000_7700_2000, 2'd0, 3'd0, 13'd3, 1'b0, 1'b0, 40'h11_1111_0000);
    chk("R6 first copy slot", 64'(rsp_idx), 64'd0);
    ins(48'h0000_7700_2000, 2'd0, 3'd0, 13'd3, 1'b0, 1'b0, 40'h22_2222_0000);
    chk("R6 second copy slot", 64'(rsp_idx), 64'd1);
    look(48'h0000_7700_2010, 3'd0, 13'd3, 1'b0);
    chk("R6 lookup finds new copy", 64'(rsp_idx), 64'd1);
    chk("R6 new pa", 64'(rsp_pa), 64'h22_2222_0010);
    issue(OP_READ_DATA, '0, 2'd0, '0, '0, 1'b0, 1'b0, '0, 3'd0);
    chk("R6 old copy invalid", 64'(rsp_word[63]), 64'd0);

    // ---- readback words (R13, R3 real)
    ins(48'h1234_5678_9ABC, 2'd1, 3'd5, 13'h1ABC, 1'b1, 1'b1, 40'h9A_BCDE_5000);
    slot = rsp_idx;
    chk("R5 reuse invalid slot", 64'(slot), 64'd0);
    issue(OP_READ_TAG, '0, 2'd0, '0, '0, 1'b0, 1'b0, '0, slot);
    chk("R13 tag word", rsp_word,
        (64'd5 << 61) | (64'd1 << 60) | (64'd2 << 56) | 64'h1234_5678_0000 | 64'h1ABC);
    issue(OP_READ_DATA, '0, 2'd0, '0, '0, 1'b0, 1'b0, '0, slot);
    chk("R13 data word", rsp_word,
        (64'd1 << 63) | (64'd1 << 61) | 64'h9A_BCDE_4000 | (64'd1 << 6));
    look(48'h1234_5678_0042, 3'd5, 13'h1ABC, 1'b1);
    chk("R3 real hit pa", 64'(rsp_pa), 64'h9A_BCDE_0042);

    // ---- invalidate all (R12)
    inval();
    look(48'h0000_7700_2000, 3'd0, 13'd3, 1'b0);
    chk("R12 entry gone", 64'(rsp_hit), 64'd0);
    look(48'h1234_5678_0042, 3'd5, 13'h1ABC, 1'b1);
    chk("R12 locked entry gone", 64'(rsp_hit), 64'd0);
    issue(OP_READ_DATA, '0, 2'd0, '0, '0, 1'b0, 1'b0, '0, 3'd1);
    chk("R12 valid bit cleared", 64'(rsp_word[63]), 64'd0);
    ins(48'h4000_0000, 2'd0, 3'd0, 13'd1, 1'b0, 1'b0, 40'h5000);
    chk("R12 next insert at slot 0", 64'(rsp_idx), 64'd0);

    finish_run();
  end

endmodule